// File: doc/BRIEF.md
# Hot-Swap Bus Segment Join Sequencer

This controller decides when a two-wire bus buffer may tie its card-side segment to its backplane-side segment. The analog parts of the buffer (supply detection, precharge driver, pass devices, rise-time current sources) are outside this block and appear only as digital levels. Its inputs are a supply-good flag that already carries hysteresis, an enable level, and the sampled levels of the data and clock lines on the card side (`sda_a`, `scl_a`) and on the backplane side (`sda_b`, `scl_b`).

After supply-good rises and enable has been held high for a wake-up delay, the block precharges the lines and waits. It joins the segments either after all four lines have read high for an unbroken idle interval, or when a STOP (card-side data rising while card-side clock is high) is seen while both backplane lines read high. Once joined, the accelerators are permitted and the ready flag goes high. Dropping enable, or losing supply-good, separates the segments on the next clock edge.

The wake-up delay and the idle interval are cycle-count parameters. At a 50 MHz clock the defaults are 150 cycles (3 us) and 4150 cycles (83 us), which together give the roughly 86 us from enable to ready.

Top module: `seg_join_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, all four outputs are low after that edge and the block is in its undervoltage state.
- R2: At any edge where `pwr_ok` is low, all outputs go low after that edge, and no line activity while `pwr_ok` is low can raise any output.
- R3: With `pwr_ok` high, the first edge after undervoltage moves the block to the shutdown state; `prechg_on` rises at the WAKE_CYC-th consecutive edge at which `en` is sampled high in the shutdown state.
- R4: In the waiting state (`prechg_on` high), `link_on` rises at the IDLE_CYC-th consecutive edge at which all four lines are sampled high; a low on any line restarts that count.
- R5: In the waiting state, `link_on` rises at the edge where `sda_a` is sampled 1 after being 0 at the previous edge, while `scl_a`, `sda_b` and `scl_b` are sampled 1 (STOP).
- R6: A STOP on the card side while either backplane line is sampled 0 does not join the segments.
- R7: `prechg_on` is high only in the waiting state; it falls at the edge where `link_on` rises, and the two are never high together.
- R8: At any edge where `en` is sampled low, all outputs go low after that edge (shutdown), and leaving shutdown again needs the full wake-up delay.
- R9: `rdy` and `accel_ok` are high exactly when `link_on` is high.
- R10: Loss of `pwr_ok` from the joined state returns the block to undervoltage; after supply returns the full wake-up and idle sequence is needed to rejoin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Supply-good level, hysteresis applied upstream |
| en | input | 1 | Enable level; low forces shutdown |
| sda_a | input | 1 | Sampled card-side data level |
| scl_a | input | 1 | Sampled card-side clock level |
| sda_b | input | 1 | Sampled backplane-side data level |
| scl_b | input | 1 | Sampled backplane-side clock level |
| link_on | output | 1 | Join command for the buffer path |
| prechg_on | output | 1 | Precharge enable |
| accel_ok | output | 1 | Rise-time accelerator permit |
| rdy | output | 1 | Ready flag, high when joined |

## Verification
The assertions watch, on every cycle, that loss of supply or enable empties all outputs on the next edge, that precharge and join never overlap, that a join only starts from the waiting state with both backplane lines high, and that precharge only starts with supply and enable present. The exact cycle at which precharge and join rise, the restart of the idle count on a single low sample, and the refusal of a STOP while a backplane line is low are timing facts that only the bench scenarios, compared against a cycle model, can show.

// File: rtl/seg_join_pkg.sv
package seg_join_pkg;

    typedef enum logic [1:0] {
        ST_UVLO   = 2'd0,
        ST_OFF    = 2'd1,
        ST_ARMED  = 2'd2,
        ST_LINKED = 2'd3
    } join_st_t;

    typedef struct packed {
        logic link;
        logic prechg;
        logic accel;
        logic rdy;
    } join_out_t;

    function automatic join_out_t decode_out(join_st_t s);
        join_out_t o;
        o.link   = (s == ST_LINKED);
        o.prechg = (s == ST_ARMED);
        o.accel  = (s == ST_LINKED);
        o.rdy    = (s == ST_LINKED);
        return o;
    endfunction

    function automatic int cnt_width(int limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/seg_line_watch.sv
module seg_line_watch (
    input  logic clk,
    input  logic rst,
    input  logic sda_a,
    input  logic scl_a,
    input  logic sda_b,
    input  logic scl_b,
    output logic all_high,
    output logic stop_ok
);
    logic sda_a_prev;

    always_ff @(posedge clk) begin
        if (rst) sda_a_prev <= 1'b1;
        else     sda_a_prev <= sda_a;
    end

    always_comb begin
        all_high = sda_a & scl_a & sda_b & scl_b;
        stop_ok  = ~sda_a_prev & all_high;
    end
endmodule

// File: rtl/seg_run_counter.sv
module seg_run_counter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    output logic hit
);
    import seg_join_pkg::*;

    localparam int W = cnt_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    always_comb hit = inc && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !inc || hit) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    initial begin
        if (LIMIT < 1) $error("seg_run_counter: LIMIT must be at least 1");
    end
endmodule

// File: rtl/seg_join_ctrl.sv
module seg_join_ctrl #(
    parameter int IDLE_CYC = 4150,
    parameter int WAKE_CYC = 150
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_ok,
    input  logic en,
    input  logic sda_a,
    input  logic scl_a,
    input  logic sda_b,
    input  logic scl_b,
    output logic link_on,
    output logic prechg_on,
    output logic accel_ok,
    output logic rdy
);
    import seg_join_pkg::*;

    join_st_t  st_q, st_nxt;
    join_out_t out_q;
    logic      all_high, stop_ok;
    logic      wake_inc, wake_hit, idle_inc, idle_hit;

    seg_line_watch u_watch (
        .clk(clk), .rst(rst),
        .sda_a(sda_a), .scl_a(scl_a), .sda_b(sda_b), .scl_b(scl_b),
        .all_high(all_high), .stop_ok(stop_ok)
    );

    always_comb begin
        wake_inc = pwr_ok && en && (st_q == ST_OFF);
        idle_inc = pwr_ok && en && (st_q == ST_ARMED) && all_high;
    end

    seg_run_counter #(.LIMIT(WAKE_CYC)) u_wake (
        .clk(clk), .rst(rst), .inc(wake_inc), .hit(wake_hit)
    );

    seg_run_counter #(.LIMIT(IDLE_CYC)) u_idle (
        .clk(clk), .rst(rst), .inc(idle_inc), .hit(idle_hit)
    );

    always_comb begin
        st_nxt = st_q;
        if (!pwr_ok) begin
            st_nxt = ST_UVLO;
        end else begin
            unique case (st_q)
                ST_UVLO:   st_nxt = ST_OFF;
                ST_OFF:    if (wake_hit) st_nxt = ST_ARMED;
                ST_ARMED: begin
                    if (!en)                     st_nxt = ST_OFF;
                    else if (idle_hit || stop_ok) st_nxt = ST_LINKED;
                end
                ST_LINKED: if (!en) st_nxt = ST_OFF;
                default:   st_nxt = ST_UVLO;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_UVLO;
            out_q <= '0;
        end else begin
            st_q  <= st_nxt;
            out_q <= decode_out(st_nxt);
        end
    end

    assign link_on   = out_q.link;
    assign prechg_on = out_q.prechg;
    assign accel_ok  = out_q.accel;
    assign rdy       = out_q.rdy;

    AST_RST_QUIET: assert property (@(posedge clk)
        rst |=> (!link_on && !prechg_on && !accel_ok && !rdy)); // R1

    AST_NO_PWR: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |=> (!link_on && !prechg_on && !accel_ok && !rdy)); // R2

    AST_EN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!link_on && !prechg_on && !accel_ok && !rdy)); // R8

    AST_PRE_LINK_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(prechg_on && link_on)); // R7

    AST_LINK_FROM_WAIT: assert property (@(posedge clk) disable iff (rst)
        $rose(link_on) |-> $past(prechg_on)); // R7

    AST_LINK_B_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(link_on) |-> $past(sda_b && scl_b)); // R5

    AST_PRE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(prechg_on) |-> $past(en && pwr_ok)); // R3

    AST_RDY_ACCEL_LINK: assert property (@(posedge clk) disable iff (rst)
        (rdy == link_on) && (accel_ok == link_on)); // R9
endmodule

// File: tb/sim_seg_join_ctrl.sv
module sim_seg_join_ctrl;
    localparam int IDLE_T = 20;
    localparam int WAKE_T = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_ok = 1'b0, en = 1'b0;
    logic sda_a = 1'b1, scl_a = 1'b1, sda_b = 1'b1, scl_b = 1'b1;
    logic link_on, prechg_on, accel_ok, rdy;

    int checks = 0;
    int fails  = 0;

    // bench model: 0 undervoltage, 1 shutdown, 2 waiting, 3 joined
    int m_st = 0, m_wake = 0, m_idle = 0;
    logic m_prev = 1'b1;

    always #10 clk = ~clk;

    seg_join_ctrl #(.IDLE_CYC(IDLE_T), .WAKE_CYC(WAKE_T)) u0 (
        .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .en(en),
        .sda_a(sda_a), .scl_a(scl_a), .sda_b(sda_b), .scl_b(scl_b),
        .link_on(link_on), .prechg_on(prechg_on), .accel_ok(accel_ok), .rdy(rdy)
    );

    function automatic logic exp_link(int s);   return s == 3; endfunction
    function automatic logic exp_prechg(int s); return s == 2; endfunction

    task automatic chk(input logic ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_step();
        logic hi, stp;
        int nx;
        hi  = sda_a & scl_a & sda_b & scl_b;
        stp = !m_prev & hi;
        nx  = m_st;
        if (rst) begin
            nx = 0; m_wake = 0; m_idle = 0;
        end else if (!pwr_ok) begin
            nx = 0;
        end else begin
            case (m_st)
                0: nx = 1;
                1: if (en) begin
                       if (m_wake == WAKE_T - 1) nx = 2; else m_wake++;
                   end
                2: if (!en) nx = 1;
                   else if (hi && m_idle == IDLE_T - 1) nx = 3;
                   else if (stp) nx = 3;
                   else if (hi) m_idle++;
                   else m_idle = 0;
                3: if (!en) nx = 1;
                default: nx = 0;
            endcase
        end
        if (!(pwr_ok && en && m_st == 1) || nx != 1) m_wake = 0;
        if (nx != 2 || !hi) m_idle = (nx == 2 && hi) ? m_idle : 0;
        m_prev = rst ? 1'b1 : sda_a;
        m_st = nx;
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(link_on == exp_link(m_st), "R4 link_on", link_on, exp_link(m_st));
        chk(prechg_on == exp_prechg(m_st), "R7 prechg_on", prechg_on, exp_prechg(m_st));
        chk(rdy == exp_link(m_st), "R9 rdy", rdy, exp_link(m_st));
        chk(accel_ok == exp_link(m_st), "R9 accel_ok", accel_ok, exp_link(m_st));
    endtask

    task automatic lines(input logic a_d, input logic a_c, input logic b_d, input logic b_c);
        sda_a = a_d; scl_a = a_c; sda_b = b_d; scl_b = b_c;
    endtask

    task automatic go_armed();
        en = 1'b0; cyc();
        en = 1'b1;
        repeat (WAKE_T) cyc();
        chk(prechg_on == 1'b1, "R3 precharge after wake delay", prechg_on, 1);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        repeat (3) cyc();
        chk({link_on, prechg_on, accel_ok, rdy} == 4'b0, "R1 reset outputs", {link_on, prechg_on, accel_ok, rdy}, 0);

        // R3 / R4: power-up timing with quiet bus
        rst = 1'b0; pwr_ok = 1'b1; en = 1'b1; lines(1, 1, 1, 1);
        n = 0;
        do begin cyc(); n++; end while (!prechg_on && n < 100);
        chk(n == WAKE_T + 1, "R3 edges to precharge", n, WAKE_T + 1);
        n = 0;
        do begin cyc(); n++; end while (!link_on && n < 100);
        chk(n == IDLE_T, "R4 idle edges to join", n, IDLE_T);
        chk(prechg_on == 1'b0, "R7 precharge dropped on join", prechg_on, 0);
        chk(rdy && accel_ok, "R9 ready and accel when joined", {rdy, accel_ok}, 3);

        // R8: enable low separates at once
        en = 1'b0; cyc();
        chk({link_on, prechg_on, accel_ok, rdy} == 4'b0, "R8 enable-off outputs", {link_on, prechg_on, accel_ok, rdy}, 0);

        // R4: one low sample restarts the idle count
        go_armed();
        repeat (IDLE_T - 2) cyc();
        lines(1, 1, 1, 0); cyc();
        lines(1, 1, 1, 1);
        repeat (IDLE_T - 1) cyc();
        chk(link_on == 1'b0, "R4 no join before restarted count ends", link_on, 0);
        cyc();
        chk(link_on == 1'b1, "R4 join after restarted count", link_on, 1);

        // R6 / R5: STOP with and without backplane high
        go_armed();
        lines(0, 1, 0, 1); cyc();
        lines(1, 1, 0, 1); cyc();
        chk(link_on == 1'b0, "R6 STOP with sda_b low ignored", link_on, 0);
        lines(0, 1, 1, 1); cyc();
        lines(1, 1, 1, 1); cyc();
        chk(link_on == 1'b1, "R5 STOP joins", link_on, 1);

        // R10 / R2: supply loss, activity ignored, full restart
        pwr_ok = 1'b0; cyc();
        chk({link_on, prechg_on, accel_ok, rdy} == 4'b0, "R10 supply loss outputs", {link_on, prechg_on, accel_ok, rdy}, 0);
        for (int i = 0; i < 40; i++) begin
            lines(1'(i % 2), 1, 1, 1); cyc();
            chk({link_on, prechg_on} == 2'b0, "R2 activity ignored in undervoltage", {link_on, prechg_on}, 0);
        end
        pwr_ok = 1'b1; lines(1, 1, 1, 1);
        n = 0;
        do begin cyc(); n++; end while (!prechg_on && n < 100);
        chk(n == WAKE_T + 1, "R10 wake delay repeated", n, WAKE_T + 1);

        // random phase against model
        for (int i = 0; i < 6000; i++) begin
            pwr_ok = ($urandom_range(0, 199) != 0);
            en     = ($urandom_range(0, 99) != 0);
            if ($urandom_range(0, 3) == 0)
                lines(1'($urandom), 1'($urandom_range(0, 5) != 0), 1'($urandom_range(0, 5) != 0), 1'($urandom_range(0, 5) != 0));
            else
                lines(1, 1, 1, 1);
            cyc();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule